// File: doc/BRIEF.md
# Load-Store Decode and Effective Address Unit

This block sits in the decode stage of a small 32-bit RISC core. It takes an instruction word and the two source register values that the register file read for it. From these it works out whether the word is a memory access, which direction and size the access has, and the effective address, which can be up to 64 bits wide. It also raises an illegal-instruction trap or a privilege trap when the access must not go ahead.

There are three addressing forms: register plus register, register plus 16-bit immediate, and an extended form that joins two registers into a wide physical address. The extended form bypasses address translation and is trapped in user mode. An upper-immediate prefix instruction can supply the top half of the next immediate. A two-state prefix machine tracks whether such a prefix is pending:
- `PFX_IDLE`: no prefix is pending.
- `PFX_HELD`: a prefix is pending and its 16 bits are latched.

The machine has three transitions, all taken on a valid instruction:
- LOAD_PFX moves from `PFX_IDLE` to `PFX_HELD` when a prefix arrives.
- RELOAD stays in `PFX_HELD` when another prefix arrives.
- CONSUME moves from `PFX_HELD` to `PFX_IDLE` on any valid instruction that is not a prefix.

The results are registered and appear one cycle after the instruction is presented.

Top module: `lsd_unit`

## Requirements
- R1: The unit classifies the major opcode `insn[31:26]`.
  - When its two top bits are `11`, the word is a memory access.
  - `insn[29]` set selects the immediate form.
  - `insn[28]` set marks a store.
  - `insn[27:26]` gives the size: 0 is byte, 1 is halfword, 2 is word.
- R2: In the register form, ra is `insn[20:16]` and rb is `insn[15:11]`. Register r0 reads as zero, and the address is the 32-bit sum of the two registers. This means one r0 leaves the other register alone as the address, and two r0 give address 0.
- R3: In the immediate form, the address is ra plus `insn[15:0]` sign-extended to 32 bits. When ra is r0, the address is the extended immediate alone. `insn[15:11]` are not read as a register in this form.
- R4: The prefix opcode `101100` latches `insn[15:0]`. The next valid instruction that is not a prefix uses those bits as the upper half of its immediate instead of the sign extension, and clears the pending prefix whatever kind of instruction it is.
- R5: In the register form only, three function bits set flags: `insn[10]` marks exclusive, `insn[9]` marks byte-reversed and `insn[7]` marks extended address. In the immediate form all three flags stay 0.
- R6: An exclusive access forces address bits [1:0] to zero.
- R7: A byte-reversed access flips the low address bits: XOR 3 for a byte, XOR 2 for a halfword, and no change for a word.
- R8: In the extended form:
  - If `cfg_addr_width` is 32 or ra is r0, the address is rb zero-extended, or 0 when rb is r0.
  - Otherwise the address is {ra, rb}, with every bit at or above `cfg_addr_width` cleared.
- R9: An extended access in kernel mode asserts `mmu_bypass`. In user mode it asserts `trap_priv` instead, with `acc_en` and `mmu_bypass` at 0.
- R10: A size code of 3, or an exclusive bit on a non-word size, asserts `trap_ill` with `acc_en` at 0.
- R11: `stk_chk` is asserted for a granted, non-extended access when `cfg_stack_prot` is 1 and r1 is ra in either form, or rb in the register form.
- R12: Every valid instruction gives `out_valid` exactly one cycle later. A non-memory instruction shows all flags, traps and the address as 0. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word is valid this cycle |
| insn | input | 32 | Instruction word |
| ra_val | input | 32 | Value read for the ra field |
| rb_val | input | 32 | Value read for the rb field |
| user_mode | input | 1 | Core is in user mode |
| cfg_stack_prot | input | 1 | Stack protection enabled |
| cfg_addr_width | input | 7 | Physical address width for the extended form, 32 to 64 |
| out_valid | output | 1 | Result of an instruction presented last cycle |
| acc_en | output | 1 | A memory access is granted |
| acc_store | output | 1 | Access is a store |
| acc_size | output | 2 | Size code |
| acc_rev | output | 1 | Byte-reversed access |
| acc_excl | output | 1 | Exclusive access |
| acc_ext | output | 1 | Extended-address access |
| mmu_bypass | output | 1 | Skip address translation |
| stk_chk | output | 1 | Request a stack-limit check |
| trap_ill | output | 1 | Illegal-instruction trap |
| trap_priv | output | 1 | Privilege trap |
| acc_addr | output | 64 | Effective address |

## Verification
The address path is tried with several register-index patterns, each telling a different case apart:
- ra and rb both nonzero, ra as r0, rb as r0, and both as r0 distinguish summing from zero-forcing.
- Positive and negative immediates separate sign extension from zero extension.
- A prefix followed by an immediate access, and a prefix consumed by a plain instruction, show when the latched half is used and when it is dropped.

The extended form is tried with widths 32, 48 and 64 and with ra as r0, which exposes concatenation and masking errors. User mode shows that the privilege trap blocks the access. Reversed and exclusive patterns on each size check the low address bits, and r1 is placed in each operand slot with stack protection on and off.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
    localparam logic [5:0] OP_PREFIX = 6'b101100;

    typedef enum logic [0:0] {
        PFX_IDLE = 1'b0,
        PFX_HELD = 1'b1
    } pfx_state_t;

    typedef struct packed {
        logic       is_ls;
        logic       imm_form;
        logic       store;
        logic [1:0] size;
        logic       rev;
        logic       excl;
        logic       ext;
        logic       illegal;
    } dec_t;
endpackage

// File: rtl/lsd_field_decode.sv
module lsd_field_decode
    import lsd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] insn,
    output dec_t            dec,
    output logic [4:0]      ra_idx,
    output logic [4:0]      rb_idx,
    output logic [15:0]     imm16,
    output logic            is_prefix
);
    logic [5:0] op;
    logic       unused_bits;

    assign op          = insn[31:26];
    assign ra_idx      = insn[20:16];
    assign rb_idx      = insn[15:11];
    assign imm16       = insn[15:0];
    assign is_prefix   = (op == OP_PREFIX);
    assign unused_bits = ^{insn[25:21], insn[8]};

    always_comb begin
        dec          = '0;
        dec.is_ls    = (op[5:4] == 2'b11);
        dec.imm_form = op[3];
        dec.store    = op[2];
        dec.size     = op[1:0];
        if (!op[3]) begin
            dec.excl = insn[10];
            dec.rev  = insn[9];
            dec.ext  = insn[7];
        end
        dec.illegal  = dec.is_ls &&
                       ((dec.size == 2'd3) || (dec.excl && dec.size != 2'd2));
    end
endmodule

// File: rtl/lsd_prefix_fsm.sv
module lsd_prefix_fsm
    import lsd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        insn_valid,
    input  logic        is_prefix,
    input  logic [15:0] imm16,
    output logic        held,
    output logic [15:0] hi
);
    pfx_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PFX_IDLE;
            hi    <= '0;
        end else begin
            state <= state_nx;
            if (insn_valid && is_prefix) hi <= imm16;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PFX_IDLE: if (insn_valid && is_prefix) state_nx = PFX_HELD;
            PFX_HELD: if (insn_valid && !is_prefix) state_nx = PFX_IDLE;
            default:  state_nx = PFX_IDLE;
        endcase
    end

    assign held = (state == PFX_HELD);

    a_r4_prefix_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && is_prefix) |=> (state == PFX_HELD));
    a_r4_prefix_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && !is_prefix) |=> (state == PFX_IDLE));
endmodule

// File: rtl/lsd_addr_gen.sv
module lsd_addr_gen
    import lsd_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int PA_W = 64,
    parameter int AW_W = 7
) (
    input  dec_t            dec,
    input  logic [4:0]      ra_idx,
    input  logic [4:0]      rb_idx,
    input  logic [XLEN-1:0] ra_val,
    input  logic [XLEN-1:0] rb_val,
    input  logic [15:0]     imm16,
    input  logic            pfx_held,
    input  logic [15:0]     pfx_hi,
    input  logic [AW_W-1:0] addr_width,
    output logic [PA_W-1:0] addr,
    output logic            r1_used
);
    localparam int WIDE = 2 * XLEN;

    logic [XLEN-1:0] ra_eff, rb_eff, imm_x, sum;
    logic [WIDE-1:0] wide;
    logic [PA_W-1:0] mask, pre;

    assign ra_eff = (ra_idx == 5'd0) ? '0 : ra_val;
    assign rb_eff = (rb_idx == 5'd0) ? '0 : rb_val;
    assign imm_x  = pfx_held ? {pfx_hi, imm16} : {{(XLEN-16){imm16[15]}}, imm16};
    assign sum    = ra_eff + (dec.imm_form ? imm_x : rb_eff);

    always_comb begin
        for (int i = 0; i < PA_W; i++) begin
            mask[i] = (i < int'(addr_width));
        end
    end

    always_comb begin
        if (int'(addr_width) <= XLEN || ra_idx == 5'd0) begin
            wide = {{XLEN{1'b0}}, rb_eff};
        end else begin
            wide = {ra_eff, rb_eff};
        end
    end

    always_comb begin
        if (dec.ext) pre = wide[PA_W-1:0] & mask;
        else         pre = PA_W'(sum);
        addr = pre;
        if (dec.excl) begin
            addr[1:0] = 2'b00;
        end else if (dec.rev) begin
            if (dec.size == 2'd0)      addr[1:0] = pre[1:0] ^ 2'b11;
            else if (dec.size == 2'd1) addr[1:0] = pre[1:0] ^ 2'b10;
        end
    end

    assign r1_used = (ra_idx == 5'd1) || (!dec.imm_form && rb_idx == 5'd1);
endmodule

// File: rtl/lsd_unit.sv
module lsd_unit
    import lsd_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int PA_W = 64,
    parameter int AW_W = $clog2(PA_W + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_valid,
    input  logic [XLEN-1:0] insn,
    input  logic [XLEN-1:0] ra_val,
    input  logic [XLEN-1:0] rb_val,
    input  logic            user_mode,
    input  logic            cfg_stack_prot,
    input  logic [AW_W-1:0] cfg_addr_width,
    output logic            out_valid,
    output logic            acc_en,
    output logic            acc_store,
    output logic [1:0]      acc_size,
    output logic            acc_rev,
    output logic            acc_excl,
    output logic            acc_ext,
    output logic            mmu_bypass,
    output logic            stk_chk,
    output logic            trap_ill,
    output logic            trap_priv,
    output logic [PA_W-1:0] acc_addr
);
    dec_t            dec;
    logic [4:0]      ra_idx, rb_idx;
    logic [15:0]     imm16, pfx_hi;
    logic            is_prefix, pfx_held, r1_used, priv_hit, grant;
    logic [PA_W-1:0] addr_c;

    lsd_field_decode #(.XLEN(XLEN)) u_dec (
        .insn(insn), .dec(dec), .ra_idx(ra_idx), .rb_idx(rb_idx),
        .imm16(imm16), .is_prefix(is_prefix)
    );

    lsd_prefix_fsm u_pfx (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .is_prefix(is_prefix),
        .imm16(imm16), .held(pfx_held), .hi(pfx_hi)
    );

    lsd_addr_gen #(.XLEN(XLEN), .PA_W(PA_W), .AW_W(AW_W)) u_agen (
        .dec(dec), .ra_idx(ra_idx), .rb_idx(rb_idx), .ra_val(ra_val),
        .rb_val(rb_val), .imm16(imm16), .pfx_held(pfx_held), .pfx_hi(pfx_hi),
        .addr_width(cfg_addr_width), .addr(addr_c), .r1_used(r1_used)
    );

    assign priv_hit = dec.ext && user_mode;
    assign grant    = !dec.illegal && !priv_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            acc_en     <= 1'b0;
            acc_store  <= 1'b0;
            acc_size   <= '0;
            acc_rev    <= 1'b0;
            acc_excl   <= 1'b0;
            acc_ext    <= 1'b0;
            mmu_bypass <= 1'b0;
            stk_chk    <= 1'b0;
            trap_ill   <= 1'b0;
            trap_priv  <= 1'b0;
            acc_addr   <= '0;
        end else begin
            out_valid  <= insn_valid;
            if (insn_valid && dec.is_ls) begin
                acc_en     <= grant;
                acc_store  <= dec.store;
                acc_size   <= dec.size;
                acc_rev    <= dec.rev;
                acc_excl   <= dec.excl;
                acc_ext    <= dec.ext;
                mmu_bypass <= dec.ext && grant;
                stk_chk    <= cfg_stack_prot && grant && !dec.ext && r1_used;
                trap_ill   <= dec.illegal;
                trap_priv  <= priv_hit;
                acc_addr   <= addr_c;
            end else begin
                acc_en     <= 1'b0;
                acc_store  <= 1'b0;
                acc_size   <= '0;
                acc_rev    <= 1'b0;
                acc_excl   <= 1'b0;
                acc_ext    <= 1'b0;
                mmu_bypass <= 1'b0;
                stk_chk    <= 1'b0;
                trap_ill   <= 1'b0;
                trap_priv  <= 1'b0;
                acc_addr   <= '0;
            end
        end
    end

    a_r9_priv_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        trap_priv |-> (!acc_en && !mmu_bypass));
    a_r6_excl_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_excl) |-> (acc_addr[1:0] == 2'b00 && acc_size == 2'd2));
    a_r12_latency: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid |=> out_valid);
    a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!acc_en && !trap_ill && !trap_priv));
    a_r2_narrow_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_ext) |-> ((acc_addr >> XLEN) == '0));
    a_r10_ill_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        trap_ill |-> !acc_en);
endmodule

// File: tb/sim_lsd_unit.sv
module sim_lsd_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn = '0, ra_val = '0, rb_val = '0;
    logic        user_mode = 1'b0, cfg_stack_prot = 1'b0;
    logic [6:0]  cfg_addr_width = 7'd64;
    logic        out_valid, acc_en, acc_store, acc_rev, acc_excl, acc_ext;
    logic        mmu_bypass, stk_chk, trap_ill, trap_priv;
    logic [1:0]  acc_size;
    logic [63:0] acc_addr;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct packed {
        logic        en, store, rev, excl, ext, byp, stk, ill, priv;
        logic [1:0]  size;
        logic [63:0] addr;
    } exp_t;

    exp_t  q_exp[$];
    string q_tag[$];
    logic        b_held = 1'b0;
    logic [15:0] b_hi = '0;

    always #10 clk = ~clk;

    lsd_unit u0 (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
        .ra_val(ra_val), .rb_val(rb_val), .user_mode(user_mode),
        .cfg_stack_prot(cfg_stack_prot), .cfg_addr_width(cfg_addr_width),
        .out_valid(out_valid), .acc_en(acc_en), .acc_store(acc_store),
        .acc_size(acc_size), .acc_rev(acc_rev), .acc_excl(acc_excl),
        .acc_ext(acc_ext), .mmu_bypass(mmu_bypass), .stk_chk(stk_chk),
        .trap_ill(trap_ill), .trap_priv(trap_priv), .acc_addr(acc_addr)
    );

    function automatic logic [31:0] rr(input logic [5:0] op, input logic [4:0] ra,
                                       input logic [4:0] rb, input logic [10:0] fn);
        return {op, 5'd3, ra, rb, fn};
    endfunction

    function automatic logic [31:0] ri(input logic [5:0] op, input logic [4:0] ra,
                                       input logic [15:0] imm);
        return {op, 5'd3, ra, imm};
    endfunction

    function automatic exp_t model(input logic [31:0] w, input logic [31:0] a,
                                   input logic [31:0] b, input logic usr,
                                   input logic sp, input int aw);
        exp_t e;
        logic        immf;
        logic [31:0] av, bv, iv;
        logic [63:0] ad, msk;
        e = '0;
        if (w[31:30] != 2'b11) return e;
        immf    = w[29];
        e.store = w[28];
        e.size  = w[27:26];
        if (!immf) begin
            e.excl = w[10];
            e.rev  = w[9];
            e.ext  = w[7];
        end
        av = (w[20:16] == 0) ? 32'd0 : a;
        bv = (w[15:11] == 0) ? 32'd0 : b;
        if (immf) begin
            iv = b_held ? {b_hi, w[15:0]} : {{16{w[15]}}, w[15:0]};
            ad = {32'd0, av + iv};
        end else if (e.ext) begin
            if (aw == 32 || w[20:16] == 0) ad = {32'd0, bv};
            else begin
                msk = (aw >= 64) ? '1 : ((64'd1 << aw) - 64'd1);
                ad  = {av, bv} & msk;
            end
        end else begin
            ad = {32'd0, av + bv};
        end
        if (e.excl) ad[1:0] = 2'b00;
        else if (e.rev && e.size == 0) ad[1:0] ^= 2'b11;
        else if (e.rev && e.size == 1) ad[1:0] ^= 2'b10;
        e.addr = ad;
        e.ill  = (e.size == 3) || (e.excl && e.size != 2);
        e.priv = e.ext && usr;
        e.en   = !e.ill && !e.priv;
        e.byp  = e.ext && e.en;
        e.stk  = sp && e.en && !e.ext &&
                 (w[20:16] == 1 || (!immf && w[15:11] == 1));
        return e;
    endfunction

    task automatic issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                         input logic usr, input logic sp, input int aw, input string tag);
        @(negedge clk);
        insn = w; ra_val = a; rb_val = b; user_mode = usr;
        cfg_stack_prot = sp; cfg_addr_width = 7'(aw); insn_valid = 1'b1;
        q_exp.push_back(model(w, a, b, usr, sp, aw));
        q_tag.push_back(tag);
        if (w[31:26] == 6'b101100) begin
            b_held = 1'b1;
            b_hi   = w[15:0];
        end else begin
            b_held = 1'b0;
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        insn_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            exp_t  e, g;
            string t;
            n_chk++;
            if (q_exp.size() == 0) begin
                n_bad++;
                $display("FAIL R12: unexpected out_valid, got 1 expected 0");
            end else begin
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                g = '{acc_en, acc_store, acc_rev, acc_excl, acc_ext, mmu_bypass,
                      stk_chk, trap_ill, trap_priv, acc_size, acc_addr};
                if (g !== e) begin
                    n_bad++;
                    $display("FAIL %s: got %h expected %h", t, g, e);
                end
            end
        end
    end

    initial begin : watchdog
        #1000000;
        n_bad++;
        n_chk++;
        $display("FAIL R12: watchdog expired, got hang expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || acc_en !== 1'b0 || acc_addr !== 64'd0 || trap_ill !== 1'b0) begin
            n_bad++;
            $display("FAIL R12: reset outputs got %b%b%h expected 0", out_valid, acc_en, acc_addr);
        end
        rst_n = 1'b1;
        // R1 R2 register form, loads and stores, r0 rules
        issue(rr(6'b110010, 5'd4, 5'd5, 11'd0), 32'h1000, 32'h0234, 0, 0, 64, "R2 sum");
        issue(rr(6'b110100, 5'd0, 5'd5, 11'd0), 32'hFFFF, 32'h0055, 0, 0, 64, "R1 store ra r0");
        issue(rr(6'b110001, 5'd4, 5'd0, 11'd0), 32'h8000_0002, 32'h77, 0, 0, 64, "R2 rb r0");
        issue(rr(6'b110000, 5'd0, 5'd0, 11'd0), 32'h5, 32'h6, 0, 0, 64, "R2 both r0");
        issue(rr(6'b110010, 5'd4, 5'd5, 11'd0), 32'hFFFF_FFFC, 32'h8, 0, 0, 64, "R2 wrap");
        // R3 immediate form
        issue(ri(6'b111010, 5'd6, 16'h0010), 32'h2000, 32'h0, 0, 0, 64, "R3 pos imm");
        issue(ri(6'b111101, 5'd6, 16'hFFF0), 32'h2000, 32'h0, 0, 0, 64, "R3 neg imm");
        issue(ri(6'b111000, 5'd0, 16'h8001), 32'h2000, 32'h0, 0, 0, 64, "R3 ra r0");
        // R4 prefix
        issue(ri(6'b101100, 5'd0, 16'hABCD), 32'h0, 32'h0, 0, 0, 64, "R4 prefix itself");
        issue(ri(6'b111010, 5'd6, 16'h8000), 32'h1, 32'h0, 0, 0, 64, "R4 prefix used");
        issue(ri(6'b111010, 5'd6, 16'h8000), 32'h1, 32'h0, 0, 0, 64, "R4 prefix gone");
        issue(ri(6'b101100, 5'd0, 16'h1234), 32'h0, 32'h0, 0, 0, 64, "R4 prefix 2");
        issue(32'h0000_0000, 32'h0, 32'h0, 0, 0, 64, "R12 non-mem consumes");
        issue(ri(6'b111010, 5'd0, 16'hFFFF), 32'h0, 32'h0, 0, 0, 64, "R4 not reused");
        // R5 R7 reversed
        issue(rr(6'b110000, 5'd4, 5'd0, 11'h200), 32'h100, 32'h0, 0, 0, 64, "R7 rev byte");
        issue(rr(6'b110101, 5'd4, 5'd0, 11'h200), 32'h102, 32'h0, 0, 0, 64, "R7 rev half");
        issue(rr(6'b110010, 5'd4, 5'd0, 11'h200), 32'h104, 32'h0, 0, 0, 64, "R7 rev word");
        issue(ri(6'b111000, 5'd4, 16'h0600), 32'h100, 32'h0, 0, 0, 64, "R5 imm no flags");
        // R6 R10 exclusive and illegal
        issue(rr(6'b110010, 5'd4, 5'd5, 11'h400), 32'h101, 32'h2, 0, 0, 64, "R6 excl align");
        issue(rr(6'b110000, 5'd4, 5'd5, 11'h400), 32'h101, 32'h2, 0, 0, 64, "R10 excl byte");
        issue(rr(6'b110011, 5'd4, 5'd5, 11'h000), 32'h101, 32'h2, 0, 0, 64, "R10 size3");
        // R8 R9 extended
        issue(rr(6'b110010, 5'd4, 5'd5, 11'h080), 32'hDEAD_BEEF, 32'h1234_5678, 0, 0, 64, "R8 ext 64");
        issue(rr(6'b110010, 5'd4, 5'd5, 11'h080), 32'hDEAD_BEEF, 32'h1234_5678, 0, 0, 48, "R8 ext 48");
        issue(rr(6'b110010, 5'd4, 5'd5, 11'h080), 32'hDEAD_BEEF, 32'h1234_5678, 0, 0, 32, "R8 ext 32");
        issue(rr(6'b110110, 5'd0, 5'd5, 11'h080), 32'hDEAD_BEEF, 32'h1234_5678, 0, 0, 64, "R8 ext ra r0");
        issue(rr(6'b110010, 5'd4, 5'd0, 11'h080), 32'h0000_0007, 32'h1234_5678, 0, 0, 64, "R8 ext rb r0");
        issue(rr(6'b110010, 5'd4, 5'd5, 11'h080), 32'h1, 32'h2, 1, 0, 64, "R9 user ext trap");
        // R11 stack check
        issue(rr(6'b110010, 5'd1, 5'd5, 11'd0), 32'h100, 32'h4, 0, 1, 64, "R11 ra r1");
        issue(rr(6'b110010, 5'd4, 5'd1, 11'd0), 32'h100, 32'h4, 0, 1, 64, "R11 rb r1");
        issue(ri(6'b111010, 5'd4, 16'h0800), 32'h100, 32'h4, 0, 1, 64, "R11 imm field r1");
        issue(ri(6'b111010, 5'd1, 16'h0008), 32'h100, 32'h4, 0, 1, 64, "R11 imm ra r1");
        issue(rr(6'b110010, 5'd1, 5'd5, 11'd0), 32'h100, 32'h4, 0, 0, 64, "R11 prot off");
        idle_cycle();
        idle_cycle();
        idle_cycle();
        n_chk++;
        if (q_exp.size() != 0) begin
            n_bad++;
            $display("FAIL R12: missing results got %0d pending expected 0", q_exp.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule